// File: doc/BRIEF.md
# Vector Mask Test and Merge Sequencer

This block steps through the elements of a 64-entry vector register of 64-bit words, one element per clock. It owns a 64-bit mask, where bit k belongs to element k. Elements are always handled in increasing index order, and a length value sets how many of them an operation touches.

A **test** operation reads operand A and checks each element against one of four conditions. It stores the outcome for each element in the matching mask bit and writes nothing to the vector write port. A **merge** operation reads operands A and B and writes one result element per clock. For each element, the mask bit decides which operand supplies the result. Either operand can be a scalar that is captured at start and used for every element.

The surrounding logic gives the block a start pulse and the operation setup. It serves the block's combinational vector read port and accepts writes from its vector write port. It waits for the single-cycle done pulse.

Top module: `vmask_seq`

## Requirements
- R1: After reset, busy, done, rd_en and wr_en are low and mask_out is all zero.
- R2: A start pulse while idle begins an operation. In the k-th clock after the start edge (k from 0), rd_en is high and rd_idx equals k.
- R3: In merge mode, the result for element k appears on the write port one clock after its read, with wr_idx equal to k. Writes come on consecutive clocks in increasing index order.
- R4: A test uses cond to pick a condition on element k of operand A: 2'b00 means the element equals zero, 2'b01 means it is nonzero, 2'b10 means bit 63 is clear, and 2'b11 means bit 63 is set. Mask bit k is set exactly when the condition holds. A test never asserts wr_en.
- R5: A test clears every mask bit whose index is at or above the length.
- R6: A merge writes element A when mask bit k is 1 and element B when it is 0. The mask is left unchanged.
- R7: When a_scalar_sel or b_scalar_sel is high at start, that operand takes the value of a_scalar or b_scalar, captured at start, for every element.
- R8: A length of 0 gives a done pulse in the first clock after start, with no reads and no writes.
- R9: A length above 64 is handled as 64.
- R10: A start pulse while busy is ignored, together with the setup inputs that come with it.
- R11: Done is a one-clock pulse in the clock after the last element's read. For a merge it comes together with the last write. With length L, done is seen L+1 clocks after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| merge | input | 1 | 1 selects merge, 0 selects test |
| cond | input | 2 | Test condition code |
| len | input | 7 | Number of elements to process |
| a_scalar_sel | input | 1 | Operand A is a scalar |
| b_scalar_sel | input | 1 | Operand B is a scalar |
| a_scalar | input | 64 | Scalar value for A |
| b_scalar | input | 64 | Scalar value for B |
| rd_en | output | 1 | Vector read active |
| rd_idx | output | 6 | Element index being read |
| a_rd_data | input | 64 | Operand A element at rd_idx (combinational) |
| b_rd_data | input | 64 | Operand B element at rd_idx (combinational) |
| wr_en | output | 1 | Result element valid |
| wr_idx | output | 6 | Result element index |
| wr_data | output | 64 | Result element value |
| mask_out | output | 64 | Current mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
The bench runs tests with a short length after a full-length test. A design that never clears the bits above the length would leave stale ones in the mask. It also runs lengths of 0 and of 100. A design that mishandles these would either issue a stray write at element 0 or wrap its counter and stop early or never. A second start pulse is sent mid-operation with a different length; a design that re-arms on it would change the number of writes. Merges use each scalar and vector mix, with operands whose sign bits and zero elements differ. This catches a swapped mask polarity, a scalar read from the vector port, and a test condition code that is decoded wrongly.

// File: rtl/vmask_seq.sv
module vmask_seq #(
  parameter int W  = 64,
  parameter int N  = 64,
  parameter int LW = $clog2(N + 1),
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          merge,
  input  logic [1:0]    cond,
  input  logic [LW-1:0] len,
  input  logic          a_scalar_sel,
  input  logic          b_scalar_sel,
  input  logic [W-1:0]  a_scalar,
  input  logic [W-1:0]  b_scalar,
  output logic          rd_en,
  output logic [IW-1:0] rd_idx,
  input  logic [W-1:0]  a_rd_data,
  input  logic [W-1:0]  b_rd_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic [N-1:0]  mask_out,
  output logic          busy,
  output logic          done
);

  logic [LW-1:0] cnt, len_q, len_eff;
  logic          merge_q, asel_q, bsel_q, hit, last;
  logic [1:0]    cond_q;
  logic [W-1:0]  asc_q, bsc_q, a_val, b_val;
  logic [N-1:0]  mask_q;

  assign len_eff  = (len > LW'(N)) ? LW'(N) : len;
  assign rd_en    = busy;
  assign rd_idx   = cnt[IW-1:0];
  assign a_val    = asel_q ? asc_q : a_rd_data;
  assign b_val    = bsel_q ? bsc_q : b_rd_data;
  assign last     = (cnt == len_q - LW'(1));
  assign mask_out = mask_q;

  always_comb begin
    case (cond_q)
      2'b00:   hit = (a_val == '0);
      2'b01:   hit = (a_val != '0);
      2'b10:   hit = !a_val[W-1];
      default: hit = a_val[W-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      mask_q  <= '0;
      cnt     <= '0;
      len_q   <= '0;
      merge_q <= 1'b0;
      cond_q  <= 2'b00;
      asel_q  <= 1'b0;
      bsel_q  <= 1'b0;
      asc_q   <= '0;
      bsc_q   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (!busy && start) begin
        merge_q <= merge;
        cond_q  <= cond;
        len_q   <= len_eff;
        asel_q  <= a_scalar_sel;
        bsel_q  <= b_scalar_sel;
        asc_q   <= a_scalar;
        bsc_q   <= b_scalar;
        cnt     <= '0;
        if (!merge) mask_q <= '0;
        if (len_eff == '0) done <= 1'b1;
        else               busy <= 1'b1;
      end else if (busy) begin
        if (merge_q) begin
          wr_en   <= 1'b1;
          wr_idx  <= rd_idx;
          wr_data <= mask_q[rd_idx] ? a_val : b_val;
        end else begin
          mask_q[rd_idx] <= hit;
        end
        cnt <= cnt + LW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_wr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + IW'(1)));
  p_rd_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q));
  p_no_wr_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> merge_q);
  p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !merge_q) |-> ((mask_q >> len_q) == '0));
  p_merge_keeps_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && merge_q && $past(busy)) |-> $stable(mask_q));

endmodule

// File: tb/tb_vmask_seq.sv
module tb_vmask_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, merge = 1'b0, a_scalar_sel = 1'b0, b_scalar_sel = 1'b0;
  logic [1:0]  cond = 2'b00;
  logic [6:0]  len = '0;
  logic [63:0] a_scalar = '0, b_scalar = '0;
  logic        rd_en, wr_en, busy, done;
  logic [5:0]  rd_idx, wr_idx;
  logic [63:0] a_rd_data, b_rd_data, wr_data, mask_out;
  logic [63:0] va [64];
  logic [63:0] vb [64];
  int checks = 0, bad = 0;

  always #10 clk = ~clk;

  assign a_rd_data = va[rd_idx];
  assign b_rd_data = vb[rd_idx];

  vmask_seq dut (.clk, .rst_n, .start, .merge, .cond, .len, .a_scalar_sel, .b_scalar_sel,
    .a_scalar, .b_scalar, .rd_en, .rd_idx, .a_rd_data, .b_rd_data, .wr_en, .wr_idx,
    .wr_data, .mask_out, .busy, .done);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [1:0] c, input logic [63:0] x);
    case (c)
      2'b00: return x == 0;
      2'b01: return x != 0;
      2'b10: return x[63] == 1'b0;
      default: return x[63] == 1'b1;
    endcase
  endfunction

  // behavioural reference model
  bit          m_busy, m_done, m_wr, m_merge, m_as, m_bs;
  int          m_k, m_len, m_widx;
  logic [1:0]  m_cond;
  logic [63:0] m_mask, m_wdata, m_asc, m_bsc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_wr = 0; m_mask = 0; m_k = 0; m_len = 0; m_widx = 0; m_wdata = 0;
    end else begin
      m_done = 0; m_wr = 0;
      if (m_busy) begin
        if (m_merge) begin
          m_wr = 1; m_widx = m_k;
          m_wdata = m_mask[m_k] ? (m_as ? m_asc : va[m_k]) : (m_bs ? m_bsc : vb[m_k]);
        end else m_mask[m_k] = cond_ok(m_cond, va[m_k]);
        m_k++;
        if (m_k == m_len) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_merge = merge; m_cond = cond; m_as = a_scalar_sel; m_bs = b_scalar_sel;
        m_asc = a_scalar; m_bsc = b_scalar; m_k = 0;
        m_len = (int'(len) > 64) ? 64 : int'(len);
        if (!merge) m_mask = 0;
        if (m_len == 0) m_done = 1; else m_busy = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(done == m_done, "R11 done vs model", 64'(done), 64'(m_done));
    chk(rd_en == m_busy, "R2 rd_en vs model", 64'(rd_en), 64'(m_busy));
    if (m_busy) chk(rd_idx == 6'(m_k), "R2 rd_idx vs model", 64'(rd_idx), 64'(m_k));
    chk(wr_en == m_wr, "R3 wr_en vs model", 64'(wr_en), 64'(m_wr));
    if (m_wr) begin
      chk(wr_idx == 6'(m_widx), "R3 wr_idx vs model", 64'(wr_idx), 64'(m_widx));
      chk(wr_data == m_wdata, "R6 wr_data vs model", wr_data, m_wdata);
    end
    chk(mask_out == m_mask, "R4 mask vs model", mask_out, m_mask);
  end

  task automatic run(input bit mg, input logic [1:0] c, input int l, input bit as, input bit bs,
                     input int glitch, input string tag, output int nwr, output int cyc);
    int lim;
    lim = (l > 64) ? 64 : l;
    @(negedge clk);
    merge = mg; cond = c; len = 7'(l); a_scalar_sel = as; b_scalar_sel = bs; start = 1'b1;
    nwr = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      start = (cyc == glitch);
      if (cyc == glitch) begin len = 7'd5; merge = ~mg; end
      if (wr_en) begin
        nwr++;
        chk(wr_data == (mask_out[wr_idx] ? (as ? a_scalar : va[wr_idx]) : (bs ? b_scalar : vb[wr_idx])),
            tag, wr_data, 64'(wr_idx));
      end
      if (done) begin
        if (mg && lim > 0)
          chk(wr_en && wr_idx == 6'(lim - 1), "R11 last write with done", 64'(wr_idx), 64'(lim - 1));
        break;
      end
      if (cyc > 200) begin
        chk(0, "R11 done timeout", 64'(cyc), 64'(lim + 1));
        break;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #3_000_000;
    chk(0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int nwr, cyc;
    logic [63:0] e;
    for (int i = 0; i < 64; i++) begin
      case (i % 4)
        0: va[i] = 64'd0;
        1: va[i] = 64'(i) * 64'd1237 + 64'd5;
        2: va[i] = {1'b1, 63'(i * 11)};
        default: va[i] = 64'(i) << 40;
      endcase
      vb[i] = ~(64'(i) * 64'h9E37_79B9_7F4A_7C15);
    end
    a_scalar = 64'hA5A5_0000_1234_5678;
    b_scalar = 64'h0F0F_F0F0_5555_AAAA;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1 idle after reset", 64'({busy, done, rd_en, wr_en}), 0);
    chk(mask_out == 0, "R1 mask after reset", mask_out, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 4; c++) begin
      run(0, 2'(c), 64, 0, 0, -1, "R4 test", nwr, cyc);
      e = 0;
      for (int i = 0; i < 64; i++) e[i] = cond_ok(2'(c), va[i]);
      chk(mask_out == e, "R4 condition mask", mask_out, e);
      chk(nwr == 0, "R4 test writes nothing", 64'(nwr), 0);
      chk(cyc == 65, "R11 done timing len 64", 64'(cyc), 65);
    end

    run(0, 2'b01, 10, 0, 0, -1, "R5 test", nwr, cyc);
    chk((mask_out >> 10) == 0, "R5 upper bits cleared", mask_out, 0);
    chk(cyc == 11, "R11 done timing len 10", 64'(cyc), 11);

    run(0, 2'b10, 64, 0, 0, -1, "R6 setup", nwr, cyc);
    e = mask_out;
    run(1, 2'b00, 64, 0, 0, -1, "R6 merge vv", nwr, cyc);
    chk(nwr == 64, "R3 merge write count", 64'(nwr), 64);
    chk(mask_out == e, "R6 mask kept by merge", mask_out, e);
    run(1, 2'b00, 40, 1, 0, -1, "R7 merge sA", nwr, cyc);
    run(1, 2'b00, 23, 0, 1, -1, "R7 merge sB", nwr, cyc);
    run(1, 2'b00, 7, 1, 1, -1, "R7 merge ss", nwr, cyc);
    chk(nwr == 7, "R7 scalar merge count", 64'(nwr), 7);

    run(1, 2'b00, 0, 0, 0, -1, "R8 merge", nwr, cyc);
    chk(nwr == 0 && cyc == 1, "R8 len0 merge", 64'({nwr, cyc}), 64'(1));
    chk(mask_out == e, "R8 len0 merge keeps mask", mask_out, e);
    run(0, 2'b01, 0, 0, 0, -1, "R8 test", nwr, cyc);
    chk(cyc == 1 && mask_out == 0, "R8 len0 test", mask_out, 0);

    run(0, 2'b11, 64, 0, 0, -1, "R9 setup", nwr, cyc);
    run(1, 2'b00, 100, 0, 0, -1, "R9 merge", nwr, cyc);
    chk(nwr == 64, "R9 clamp writes", 64'(nwr), 64);
    chk(cyc == 65, "R9 clamp timing", 64'(cyc), 65);

    run(1, 2'b00, 20, 0, 1, 3, "R10 merge", nwr, cyc);
    chk(nwr == 20, "R10 restart ignored writes", 64'(nwr), 20);
    chk(cyc == 21, "R10 restart ignored timing", 64'(cyc), 21);

    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en, "R11 idle at end", 64'({busy, done, wr_en}), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule